// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans one GPIO input before pin-status and interrupt logic look at it. The raw pin is first brought into the slow real-time tick domain by a two-flop synchronizer. A filter then decides when the cleaned level may follow the pin. The whole block runs on the tick clock, so one clock edge is one tick.

The filter time is a 4-bit count multiplied by one of four tick units, and the two unit-select bits pick the unit. A 2-bit type field picks the behaviour. Type zero switches filtering off, and the synchronized pin is then copied straight to the output. The other three types are: reject glitches of both polarities, let low pulses through at once, or let high pulses through at once. A flag output shows when the filter is switched off. On reset the filter seeds itself from the pin, so it does not start with a stale level.

Top module: `pin_debounce`

## Requirements
- R1: While reset is asserted, `pin_level` is 0. After reset is released with the pin held steady, `pin_level` equals the pin level no later than the fifth clock edge, with no filter delay.
- R2: With `cfg_mode` = 2'b00 (filter off), `filter_off` is 1. Every change of `pin_raw` reaches `pin_level` at the third clock edge after the change, through two synchronizer flops and one output register.
- R3: `filter_off` is 0 whenever `cfg_mode` is not 2'b00.
- R4: The tick unit is picked by {`cfg_unit_large`, `cfg_unit_fine`]: 2'b00 is 2 ticks, 2'b01 is 8 ticks, 2'b10 is 512 ticks and 2'b11 is 2048 ticks.
- R5: The filter time T is `cfg_count` × unit. A count of 0 is treated as 1 while filtering is on.
- R6: With `cfg_mode` = 2'b11 (reject both), a change of `pin_raw` in either direction that is then held reaches `pin_level` at clock edge T+2 after the change.
- R7: In a timed direction, any synchronized sample back at the current output level restarts the timer. A pulse that lasts fewer than T ticks never reaches `pin_level`, and after such a pulse a held change again takes T+2 edges.
- R8: With `cfg_mode` = 2'b01 (keep low pulses), a fall reaches `pin_level` at the third edge, even for a one-tick pulse. A rise is timed as in R6, and a high pulse shorter than T is dropped.
- R9: With `cfg_mode` = 2'b10 (keep high pulses), a rise reaches `pin_level` at the third edge, even for a one-tick pulse. A fall is timed as in R6, and a low pulse shorter than T is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tick | input | 1 | Real-time tick clock; one edge is one tick |
| rst_tick_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_raw | input | 1 | Asynchronous pin level |
| cfg_count | input | CNT_W (4) | Filter time in units |
| cfg_unit_large | input | 1 | Upper unit-select bit |
| cfg_unit_fine | input | 1 | Lower unit-select bit |
| cfg_mode | input | 2 | Filter type: 00 off, 01 keep low pulses, 10 keep high pulses, 11 reject both |
| pin_level | output | 1 | Filtered, registered pin level |
| filter_off | output | 1 | High when the filter type is off |

## Verification
A pin change takes two edges to cross the synchronizer, and the output register adds one more. An immediate result is therefore due at the third edge after the pin is driven, and a timed one at edge T+2. Every delay scenario drives the pin on a falling edge and counts rising edges until `pin_level` shows the new value, sampling on the falling edge after each. The count is then compared to 3 or T+2 exactly, so an early change fails as clearly as a late one. Pulse scenarios watch the output on every falling edge for longer than T+2 edges, so a pulse that should be dropped is never missed. After reset, the seeded level is checked at the fifth edge after release, which counts the two reset-release flops.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    DBF_PASS    = 2'b00,
    DBF_KEEP_LO = 2'b01,
    DBF_KEEP_HI = 2'b10,
    DBF_SCRUB   = 2'b11
  } dbf_mode_e;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbf_limit.sv
module dbf_limit #(
  parameter int CNT_W = 4,
  parameter int SH0   = 1,
  parameter int SH1   = 3,
  parameter int SH2   = 9,
  parameter int SH3   = 11,
  localparam int TMR_W = CNT_W + SH3
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       unit_sel,
  output logic [TMR_W-1:0] limit
);
  logic [TMR_W-1:0] eff;

  always_comb begin
    eff = (count == '0) ? TMR_W'(1) : TMR_W'(count);
    unique case (unit_sel)
      2'b00:   limit = eff << SH0;
      2'b01:   limit = eff << SH1;
      2'b10:   limit = eff << SH2;
      default: limit = eff << SH3;
    endcase
  end
endmodule

// File: rtl/dbf_core.sv
module dbf_core
  import dbf_pkg::*;
#(
  parameter int TMR_W  = 15,
  parameter int STAGES = 2,
  localparam int WARM_W = $clog2(STAGES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  dbf_mode_e        mode,
  input  logic [TMR_W-1:0] limit,
  output logic             level,
  output logic [TMR_W-1:0] run_cnt
);
  logic              lvl_q, lvl_d;
  logic [TMR_W-1:0]  cnt_q, cnt_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [TMR_W:0]    cnt_inc;
  logic              fast_dir;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + (TMR_W+1)'(1);
    fast_dir = (mode == DBF_KEEP_LO && !smp) || (mode == DBF_KEEP_HI && smp);
    lvl_d    = lvl_q;
    cnt_d    = cnt_q;
    warm_d   = warm_q;
    if (warm_q <= WARM_W'(STAGES)) begin
      warm_d = warm_q + WARM_W'(1);
      lvl_d  = smp;
      cnt_d  = '0;
    end else if (mode == DBF_PASS || smp == lvl_q || fast_dir) begin
      lvl_d = smp;
      cnt_d = '0;
    end else if (cnt_inc >= {1'b0, limit}) begin
      lvl_d = smp;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[TMR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      warm_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      warm_q <= warm_d;
    end
  end

  assign level   = lvl_q;
  assign run_cnt = cnt_q;
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbf_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int STAGES = 2,
  parameter int SH0    = 1,
  parameter int SH1    = 3,
  parameter int SH2    = 9,
  parameter int SH3    = 11,
  localparam int TMR_W = CNT_W + SH3
) (
  input  logic             clk_tick,
  input  logic             rst_tick_n,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_unit_large,
  input  logic             cfg_unit_fine,
  input  logic [1:0]       cfg_mode,
  output logic             pin_level,
  output logic             filter_off
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             pin_smp;
  logic [TMR_W-1:0] limit;
  logic [TMR_W-1:0] run_cnt;
  dbf_mode_e        mode;

  always_ff @(posedge clk_tick or negedge rst_tick_n) begin
    if (!rst_tick_n) rst_pipe <= '0;
    else             rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign mode       = dbf_mode_e'(cfg_mode);
  assign filter_off = (mode == DBF_PASS);

  dbf_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk_tick), .rst_n(rst_sync_n), .d(pin_raw), .q(pin_smp)
  );

  dbf_limit #(.CNT_W(CNT_W), .SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3)) u_limit (
    .count(cfg_count), .unit_sel({cfg_unit_large, cfg_unit_fine}), .limit(limit)
  );

  dbf_core #(.TMR_W(TMR_W), .STAGES(STAGES)) u_core (
    .clk(clk_tick), .rst_n(rst_sync_n), .smp(pin_smp), .mode(mode),
    .limit(limit), .level(pin_level), .run_cnt(run_cnt)
  );
endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk #(
  parameter int TMR_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin,
  input logic [1:0]       mode,
  input logic             level,
  input logic [TMR_W-1:0] run_cnt,
  input logic [TMR_W-1:0] limit
);
  logic [2:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= '0;
    else if (since != 3'd7)  since <= since + 3'd1;
  end

  a_r2_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7 && $past(mode) == 2'b00) |-> level == $past(pin, 3));

  a_r6_held_before_change: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7 && $past(mode) == 2'b11 && $past(mode, 2) == 2'b11 &&
     $past(limit) >= 2 && level != $past(level))
    |-> ($past(pin, 3) == level && $past(pin, 4) == level));

  a_r7_timer_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7 && $past(limit) == limit) |-> run_cnt < limit);

  a_r8_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7 && $past(mode) == 2'b01 && $past(pin, 3) == 1'b0) |-> level == 1'b0);

  a_r9_high_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7 && $past(mode) == 2'b10 && $past(pin, 3) == 1'b1) |-> level == 1'b1);
endmodule

bind pin_debounce pin_debounce_chk u_chk (
  .clk(clk_tick), .rst_n(rst_sync_n), .pin(pin_raw), .mode(cfg_mode),
  .level(pin_level), .run_cnt(run_cnt), .limit(limit)
);

// File: tb/pin_debounce_bench.sv
module pin_debounce_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic [3:0] cnt;
  logic       ularge, ufine;
  logic [1:0] mode;
  logic       lvl, off;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  pin_debounce u_pin_debounce (
    .clk_tick(clk), .rst_tick_n(rst_n), .pin_raw(pin), .cfg_count(cnt),
    .cfg_unit_large(ularge), .cfg_unit_fine(ufine), .cfg_mode(mode),
    .pin_level(lvl), .filter_off(off)
  );

  task automatic check_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic [1:0] m, logic lg, logic fn, logic [3:0] c);
    @(negedge clk);
    mode = m; ularge = lg; ufine = fn; cnt = c;
  endtask

  task automatic settle(logic v, int cycles);
    @(negedge clk);
    pin = v;
    repeat (cycles) @(negedge clk);
  endtask

  // drive a held change, count edges until the output shows it
  task automatic measure(string req, logic v, int exp);
    int n = 0;
    @(negedge clk);
    pin = v;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (lvl != v && n < exp + 6);
    check_int(req, n, exp);
  endtask

  // pulse of w ticks at level v; report whether the output ever left its start level
  task automatic pulse(string req, logic v, int w, int watch, int exp_seen);
    logic base;
    int   seen = 0;
    @(negedge clk);
    base = lvl;
    pin = v;
    repeat (w) begin
      @(negedge clk);
      if (lvl != base) seen = 1;
    end
    pin = ~v;
    repeat (watch) begin
      @(negedge clk);
      if (lvl != base) seen = 1;
    end
    check_int(req, seen, exp_seen);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin = 1'b1;
    mode = 2'b11; ularge = 1'b0; ufine = 1'b0; cnt = 4'd3;
    repeat (3) @(negedge clk);
    check_int("R1 level in reset", int'(lvl), 0);
    check_int("R3 flag with filter on", int'(off), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_int("R1 seeded level at fifth edge", int'(lvl), 1);
  endtask

  task automatic t_pass;
    set_cfg(2'b00, 1'b0, 1'b1, 4'd9);
    settle(1'b1, 4);
    check_int("R2 flag when off", int'(off), 1);
    measure("R2 fall latency", 1'b0, 3);
    measure("R2 rise latency", 1'b1, 3);
  endtask

  task automatic t_units;
    set_cfg(2'b11, 1'b0, 1'b0, 4'd1);
    settle(1'b0, 8);
    check_int("R3 flag in reject mode", int'(off), 0);
    measure("R4 unit 00 rise", 1'b1, 4);
    measure("R4 unit 00 fall", 1'b0, 4);
    set_cfg(2'b11, 1'b0, 1'b1, 4'd1);
    measure("R4 unit 01 rise", 1'b1, 10);
    set_cfg(2'b11, 1'b1, 1'b0, 4'd1);
    measure("R4 unit 10 fall", 1'b0, 514);
    set_cfg(2'b11, 1'b1, 1'b1, 4'd1);
    measure("R4 unit 11 rise", 1'b1, 2050);
  endtask

  task automatic t_count;
    set_cfg(2'b11, 1'b0, 1'b0, 4'd5);
    measure("R5 count 5 fall", 1'b0, 12);
    set_cfg(2'b11, 1'b0, 1'b1, 4'd0);
    measure("R5 count 0 as one unit", 1'b1, 10);
    set_cfg(2'b11, 1'b0, 1'b0, 4'd15);
    measure("R5 count 15 fall", 1'b0, 32);
    set_cfg(2'b11, 1'b0, 1'b1, 4'd2);
    measure("R6 both-reject rise T=16", 1'b1, 18);
  endtask

  task automatic t_scrub_pulses;
    set_cfg(2'b11, 1'b0, 1'b0, 4'd3);   // T = 6
    settle(1'b0, 10);
    pulse("R7 short high pulse dropped", 1'b1, 5, 12, 0);
    settle(1'b1, 12);
    check_int("R6 held rise arrives", int'(lvl), 1);
    pulse("R7 short low pulse dropped", 1'b0, 5, 12, 0);
    pulse("R6 full-length low pulse passes", 1'b0, 6, 12, 1);
    settle(1'b0, 12);
    @(negedge clk);
    pin = 1'b1;
    repeat (5) @(negedge clk);
    pin = 1'b0;
    @(negedge clk);
    check_int("R7 no change before restart", int'(lvl), 0);
    measure("R7 restart needs full time", 1'b1, 8);
  endtask

  task automatic t_keep_low;
    set_cfg(2'b01, 1'b0, 1'b0, 4'd3);   // T = 6
    settle(1'b1, 10);
    check_int("R3 flag in keep-low mode", int'(off), 0);
    measure("R8 fall is immediate", 1'b0, 3);
    measure("R8 rise is timed", 1'b1, 8);
    pulse("R8 one-tick low pulse passes", 1'b0, 1, 6, 1);
    settle(1'b1, 12);
    settle(1'b0, 6);
    pulse("R8 short high pulse dropped", 1'b1, 5, 12, 0);
  endtask

  task automatic t_keep_high;
    set_cfg(2'b10, 1'b0, 1'b0, 4'd3);   // T = 6
    settle(1'b0, 10);
    check_int("R3 flag in keep-high mode", int'(off), 0);
    measure("R9 rise is immediate", 1'b1, 3);
    measure("R9 fall is timed", 1'b0, 8);
    pulse("R9 one-tick high pulse passes", 1'b1, 1, 6, 1);
    settle(1'b0, 12);
    settle(1'b1, 6);
    pulse("R9 short low pulse dropped", 1'b0, 5, 12, 0);
  endtask

  initial begin
    t_reset;
    t_pass;
    t_units;
    t_count;
    t_scrub_pulses;
    t_keep_low;
    t_keep_high;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1..R9 run actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule